// File: doc/BRIEF.md
# Nested priority interrupt controller

The controller collects interrupt requests from up to eight device lines, each tied to a fixed urgency level from 0 (least urgent) to 7 (most urgent). Each device line passes through a two-flop synchroniser. A rising edge on the line latches a pending bit for that level. The pending bit stays set until software clears it through the register port. A per-level enable mask and a global enable decide which pending levels are eligible. The highest eligible level is offered to the processor on a vector output.

The controller keeps a running priority, which is the level of the handler currently being serviced. It also keeps an idle state for the case where no handler is active. The request to the processor is raised only when the offered level is strictly more urgent than the running priority. A more urgent device can therefore interrupt a handler, but a device at the same or a lower level cannot. This prevents recursive entry.

When the processor acknowledges, the old running state is pushed onto an eight-entry save stack and the running priority becomes the serviced level. A return pulse pops the saved state back. Software reaches the mask, the global enable, the per-level clear, the pending bits and the running priority through a small word-addressed register port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A rising edge on `dev_req_i[n]` sets pending bit n no later than four clocks after the edge. A line that is held high does not set the bit again after software clears it; only a new rising edge does.
- R2: Pending bits are read at address 2. Writing to address 2 clears each pending bit whose data bit is 1 and leaves the other pending bits unchanged.
- R3: The mask register at address 0 is read/write, and bit n enables level n. It resets to 0. A pending level whose mask bit is 0 never drives `irq_o` and never appears on `irq_vec_o`.
- R4: Bit 0 of the control register at address 1 is the global enable, and it resets to 0. While the global enable is 0, `irq_o` stays low, but pending bits are still latched and kept.
- R5: `irq_vec_o` gives the highest level that is both pending and unmasked. It reads 0 when no level is eligible.
- R6: `irq_o` is high exactly when the global enable is 1, some level is eligible, and either no handler is active or the `irq_vec_o` level is strictly greater than the running level.
- R7: A pulse on `irq_ack_i` while `irq_o` is high pushes the current running state onto the save stack and makes the `irq_vec_o` level the running level. A pulse on `irq_ack_i` while `irq_o` is low changes nothing.
- R8: A pulse on `rte_i` restores the most recently pushed running state. If the stack is empty, the pulse returns the controller to idle.
- R9: Address 3 reads the running state. Bit 3 is set while a handler is active, and bits 2:0 hold the running level. The idle state reads 0.
- R10: Bit 1 of address 1 is a sticky overflow flag, set when an acknowledge pushes onto a full stack. Nesting through all eight levels, 0 to 7, fills the stack without setting the flag, and eight returns unwind the levels in reverse order.
- R11: When `irq_ack_i` and `rte_i` are high in the same cycle, the acknowledge is carried out and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_req_i | input | 8 | Asynchronous device request lines, index = level |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Read data of the addressed register |
| irq_ack_i | input | 1 | Processor accepts the offered interrupt |
| rte_i | input | 1 | Processor returns from the current handler |
| irq_o | output | 1 | Interrupt request to the processor |
| irq_vec_o | output | 3 | Level of the highest eligible source |

## Verification
The bench raises a second request at the level already being serviced. A design that compared with greater-or-equal would re-enter the handler recursively. It also nests through every level and then unwinds. A stack with an off-by-one count would either report a false overflow or restore the wrong level. A return with an empty stack should go back to idle rather than wrap the count. The bench also holds a request line high across a clear, which catches a level-sensitive latch that re-sets the pending bit. Finally, it drives an acknowledge and a return together, which exposes a design that gives the return priority.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  localparam int unsigned REG_AW = 2;
  typedef enum logic [REG_AW-1:0] {
    REG_MASK = 2'd0,
    REG_CTRL = 2'd1,
    REG_PEND = 2'd2,
    REG_PRIO = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pic_req_sync.sv
`timescale 1ns/1ps
module pic_req_sync #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [2:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '0;
      else         sr_q <= {sr_q[1:0], req_i[g]};
    end
    assign rise_o[g] = sr_q[1] & ~sr_q[2];

    // single-cycle edge pulse
    assert_rise_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/pic_pend.sv
`timescale 1ns/1ps
module pic_pend #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       p_q <= 1'b0;
      else if (set_i[g]) p_q <= 1'b1;  // new event beats a clear
      else if (clr_i[g]) p_q <= 1'b0;
    end
    assign pend_o[g] = p_q;

    assert_set_latches_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> pend_o[g]);
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[g] && !clr_i[g]) |=> pend_o[g]);
  end
endmodule

// File: rtl/pic_resolve.sv
`timescale 1ns/1ps
module pic_resolve #(
  parameter int unsigned N     = 8,
  localparam int unsigned LW   = $clog2(N)
) (
  input  logic [N-1:0]  elig_i,
  output logic          any_o,
  output logic [LW-1:0] lvl_o
);
  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i]) lvl_o = LW'(i);
    end
  end
  assign any_o = |elig_i;
endmodule

// File: rtl/pic_prio_stack.sv
`timescale 1ns/1ps
module pic_prio_stack #(
  parameter int unsigned W     = 4,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] wr_idx, top_idx;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign wr_idx  = IW'(cnt_q);
  assign top_idx = IW'(cnt_q - CW'(1));
  assign top_o   = mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (push_i && !full_o)   cnt_q <= cnt_q + CW'(1);
    else if (!push_i && pop_i && !empty_o) cnt_q <= cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[wr_idx] <= din_i;
  end

  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_pop_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> empty_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl #(
  parameter int unsigned NUM_LVL     = 8,
  parameter int unsigned STACK_DEPTH = 8,
  parameter int unsigned DATA_W      = 8,
  localparam int unsigned LVL_W      = $clog2(NUM_LVL),
  localparam int unsigned ST_W       = LVL_W + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_LVL-1:0]         dev_req_i,
  input  logic                       bus_we_i,
  input  logic [pic_pkg::REG_AW-1:0] bus_addr_i,
  input  logic [DATA_W-1:0]          bus_wdata_i,
  output logic [DATA_W-1:0]          bus_rdata_o,
  input  logic                       irq_ack_i,
  input  logic                       rte_i,
  output logic                       irq_o,
  output logic [LVL_W-1:0]           irq_vec_o
);
  import pic_pkg::*;

  logic [NUM_LVL-1:0] rise, pend, clr, mask_q;
  logic               ge_q, ovf_q;
  logic [ST_W-1:0]    cur_q, stk_top;
  logic               win_any, preempt, take_ack, do_pop;
  logic               stk_empty, stk_full;
  reg_addr_e          addr;

  assign addr = reg_addr_e'(bus_addr_i);

  pic_req_sync #(.N(NUM_LVL)) u_sync (
    .clk_i, .rst_ni, .req_i(dev_req_i), .rise_o(rise)
  );

  assign clr = (bus_we_i && addr == REG_PEND) ? bus_wdata_i[NUM_LVL-1:0] : '0;

  pic_pend #(.N(NUM_LVL)) u_pend (
    .clk_i, .rst_ni, .set_i(rise), .clr_i(clr), .pend_o(pend)
  );

  pic_resolve #(.N(NUM_LVL)) u_res (
    .elig_i(pend & mask_q), .any_o(win_any), .lvl_o(irq_vec_o)
  );

  // idle (active bit clear) sits below every level
  assign preempt  = !cur_q[LVL_W] || (irq_vec_o > cur_q[LVL_W-1:0]);
  assign irq_o    = ge_q && win_any && preempt;
  assign take_ack = irq_ack_i && irq_o;
  assign do_pop   = rte_i && !take_ack;

  pic_prio_stack #(.W(ST_W), .DEPTH(STACK_DEPTH)) u_stk (
    .clk_i, .rst_ni, .push_i(take_ack), .pop_i(do_pop), .din_i(cur_q),
    .top_o(stk_top), .empty_o(stk_empty), .full_o(stk_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      ovf_q <= 1'b0;
    end else if (take_ack) begin
      cur_q <= {1'b1, irq_vec_o};
      if (stk_full) ovf_q <= 1'b1;
    end else if (do_pop) begin
      cur_q <= stk_empty ? '0 : stk_top;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      ge_q   <= 1'b0;
    end else if (bus_we_i) begin
      if (addr == REG_MASK) mask_q <= bus_wdata_i[NUM_LVL-1:0];
      if (addr == REG_CTRL) ge_q   <= bus_wdata_i[0];
    end
  end

  always_comb begin
    unique case (addr)
      REG_MASK: bus_rdata_o = DATA_W'(mask_q);
      REG_CTRL: bus_rdata_o = DATA_W'({ovf_q, ge_q});
      REG_PEND: bus_rdata_o = DATA_W'(pend);
      REG_PRIO: bus_rdata_o = DATA_W'(cur_q);
      default:  bus_rdata_o = '0;
    endcase
  end

  assert_irq_eligible_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend[irq_vec_o] && mask_q[irq_vec_o]));
  assert_ack_raises_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && irq_o) |=> (cur_q == {1'b1, $past(irq_vec_o)}));
  assert_cur_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rte_i && !irq_ack_i) |=> $stable(cur_q));
  assert_no_recursion_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && cur_q[LVL_W]) |-> (irq_vec_o > cur_q[LVL_W-1:0]));
  assert_ovf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dev_req = '0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ack = 1'b0, rte = 1'b0;
  logic       irq;
  logic [2:0] vec;

  int total = 0, bad = 0;

  // model state
  logic [7:0] m_pend = '0, m_mask = '0;
  logic       m_ge = 1'b0, m_ovf = 1'b0;
  logic [3:0] m_cur = '0;
  logic [3:0] m_stk [8];
  int         m_cnt = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dev_req_i(dev_req),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_ack_i(ack), .rte_i(rte), .irq_o(irq), .irq_vec_o(vec)
  );

  function automatic logic [2:0] f_win(logic [7:0] e);
    logic [2:0] w = '0;
    for (int i = 0; i < 8; i++) if (e[i]) w = 3'(i);
    return w;
  endfunction

  function automatic logic f_irq();
    logic [7:0] e = m_pend & m_mask;
    if (!m_ge || e == '0) return 1'b0;
    return !m_cur[3] || (f_win(e) > m_cur[2:0]);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic verify(input string req);
    logic [7:0] d;
    chk(irq === f_irq(), {req, " irq"}, irq, f_irq());
    chk(vec === f_win(m_pend & m_mask), {req, " vec"}, vec, f_win(m_pend & m_mask));
    rd(2'd3, d);
    chk(d === {4'h0, m_cur}, {req, " prio"}, d, m_cur);
    rd(2'd2, d);
    chk(d === m_pend, {req, " pend"}, d, m_pend);
    rd(2'd1, d);
    chk(d === {6'h0, m_ovf, m_ge}, {req, " ctrl"}, d, {m_ovf, m_ge});
  endtask

  task automatic pulse(input logic [7:0] b);
    @(negedge clk); dev_req = b;
    @(negedge clk); dev_req = '0;
    repeat (5) @(negedge clk);
    m_pend |= b;
  endtask

  task automatic m_ack();
    if (f_irq()) begin
      if (m_cnt < 8) begin m_stk[m_cnt] = m_cur; m_cnt++; end
      else m_ovf = 1'b1;
      m_cur = {1'b1, f_win(m_pend & m_mask)};
    end
  endtask

  task automatic m_rte();
    if (m_cnt > 0) begin m_cnt--; m_cur = m_stk[m_cnt]; end
    else m_cur = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1; m_ack();
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_rte();
    @(negedge clk); rte = 1'b1; m_rte();
    @(negedge clk); rte = 1'b0;
  endtask

  task automatic do_mask(input logic [7:0] v); wr(2'd0, v); m_mask = v; endtask
  task automatic do_ge(input logic v);        wr(2'd1, {7'h0, v}); m_ge = v; endtask
  task automatic do_clr(input logic [7:0] v); wr(2'd2, v); m_pend &= ~v; endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state: R3 R4 R9
    verify("R9 reset");
    rd(2'd0, d); chk(d === 8'h00, "R3 mask reset", d, 0);

    // R4: pending latched while disabled, no irq
    do_mask(8'hFF);
    pulse(8'h04);
    verify("R4 disabled");
    do_ack(); verify("R7 ack ignored when irq low");
    do_ge(1'b1);
    verify("R6 idle request");

    // R7/R6 nesting: level 2 then same level blocked, 5 preempts
    do_ack(); verify("R7 enter level 2");
    do_clr(8'h04); pulse(8'h04);
    verify("R6 same level blocked");
    pulse(8'h20); verify("R5 level 5 wins");
    do_ack(); verify("R7 preempt to 5");
    do_rte(); verify("R8 back to 2");
    do_rte(); verify("R8 back to idle");
    do_rte(); verify("R8 empty pop idle");

    // R3 masking
    do_clr(8'hFF);
    do_mask(8'hBF); pulse(8'h41);
    verify("R3 masked level 6");
    // R2 partial clear
    pulse(8'h12); do_clr(8'h02);
    verify("R2 partial clear");
    do_clr(8'hFF); do_mask(8'hFF);

    // R1 held line does not re-set after clear
    @(negedge clk); dev_req = 8'h08;
    repeat (5) @(negedge clk); m_pend |= 8'h08;
    verify("R1 held set");
    do_clr(8'h08); repeat (5) @(negedge clk);
    verify("R1 held no re-set");
    @(negedge clk); dev_req = '0; repeat (4) @(negedge clk);
    pulse(8'h08); verify("R1 new edge");
    do_clr(8'hFF);

    // R11 ack beats rte
    pulse(8'h10);
    @(negedge clk); ack = 1'b1; rte = 1'b1; m_ack();
    @(negedge clk); ack = 1'b0; rte = 1'b0;
    verify("R11 ack over rte");
    do_rte(); do_clr(8'hFF);

    // R10 full nesting 0..7 and unwind
    for (int l = 0; l < 8; l++) begin
      pulse(8'(1 << l)); do_ack();
      verify("R10 nest");
    end
    do_rte(); verify("R10 unwind");
    for (int l = 0; l < 7; l++) begin do_rte(); verify("R10 unwind"); end
    do_clr(8'hFF);

    // random mix (R5 R6 R7 R8)
    for (int n = 0; n < 300; n++) begin
      case ($urandom % 7)
        0, 1: pulse(8'($urandom));
        2: do_mask(8'($urandom));
        3: do_clr(8'($urandom));
        4: do_ge(($urandom % 4) != 0);
        5: do_ack();
        default: do_rte();
      endcase
      verify("R6 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule